// File: doc/BRIEF.md
# Configuration Stream Sync and Identity Gate

This block watches a serial configuration stream, one bit per cycle in which the input valid is high, and hunts for a fixed 32-bit synchronization pattern. The pattern is looked for after every accepted bit, so it is found wherever it falls relative to any byte or word grid in the stream. Every bit seen before the pattern is dropped.

Once the pattern has been seen, the next 32 bits form the device identifier. The block compares them with its own identifier, which is a parameter. If the two match, each later group of 32 bits leaves the block as one configuration word with a one-cycle strobe. If they differ, an error flag is set and held, and no word is forwarded. Only a restart pulse or a reset clears it. A restart also sends the block back to hunting. Decoding of the payload words is left to the logic downstream.

Top module: `cfg_sync_gate`

## Requirements
- R1: While reset is held low at a clock edge, and after that edge, `sync_found`, `id_ok`, `id_err` and `word_vld` are 0.
- R2: `sync_found` rises in the cycle after the edge that accepts the last bit of the pattern 0xAA995566. Bits are taken MSB first, and any number of leading bits (0 to 31 or more) may come before the pattern. It stays 0 until that edge.
- R3: No bit accepted before the pattern completes is ever forwarded: `word_vld` stays 0 until the identifier has been accepted.
- R4: The 32 bits after the last pattern bit are the identifier, MSB first. If it equals `DEVICE_ID` (default 0x02088093), `id_ok` is 1 from the cycle after its last bit is accepted.
- R5: If the identifier differs from `DEVICE_ID`, `id_err` is 1 from the cycle after its last bit, `id_ok` stays 0, and `word_vld` is never raised.
- R6: `id_err` is held while `restart` stays low, whatever the stream carries afterwards, including a fresh pattern and a matching identifier. No word is forwarded while it is held.
- R7: After a match, each following group of 32 accepted bits is presented MSB first on `word_out`, with `word_vld` high for exactly one cycle: the cycle after the edge that accepts its last bit.
- R8: A `restart` high at an edge clears `sync_found`, `id_ok`, `id_err` and `word_vld` after that edge and restarts the hunt with an empty window. A bit presented in that same cycle is discarded.
- R9: Cycles with `bit_vld` low change nothing. Idle cycles between bits give the same words and flags as a gap-free stream.
- R10: `id_ok` and `id_err` are never both 1, and either one being 1 implies `sync_found` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial stream bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| restart | input | 1 | Synchronous restart of the hunt, clears all flags |
| word_out | output | 32 | Last forwarded configuration word |
| word_vld | output | 1 | One-cycle strobe for `word_out` |
| sync_found | output | 1 | Pattern has been seen since the last restart |
| id_ok | output | 1 | Identifier matched |
| id_err | output | 1 | Identifier mismatched (sticky) |

## Verification
The assertions assume that `bit_vld` and `restart` are sampled only at rising edges and hold no unknown values after reset. They also assume that a strobe or flag change can follow only from an accepted bit or a restart. The stimulus changes inputs only on falling edges and always pulses restart with `bit_vld` either low or deliberately high to test the discard case. The pattern overlaps itself only over its first and last two bits. For that reason every leading bit string is chosen so it does not end with the pattern's first thirty bits, which would cause an earlier match than the bench expects.

// File: rtl/cfg_sync_pkg.sv
// Shared types for the configuration sync gate.
// Assumes: nothing beyond a 2-bit state encoding.
package cfg_sync_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,   // searching for the pattern
        ST_ID   = 2'd1,   // gathering the identifier
        ST_LOAD = 2'd2,   // forwarding payload words
        ST_FAIL = 2'd3    // identifier mismatch, held
    } cfg_state_t;

endpackage

// File: rtl/cfg_sync_hunter.sv
// Sliding-window pattern detector.
// Shifts one bit per enabled cycle into a W-bit window, MSB first, and flags
// a hit combinationally when the window including the current bit equals
// PATTERN. Assumes the caller stops enabling it once the hit is taken.
module cfg_sync_hunter #(
    parameter int          W       = 32,
    parameter logic [W-1:0] PATTERN = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_en,
    input  logic bit_in,
    output logic hit
);

    logic [W-1:0] window;
    logic [W-1:0] window_nx;

    // next window content including the bit on the input this cycle
    assign window_nx = {window[W-2:0], bit_in};
    assign hit       = shift_en && (window_nx == PATTERN);

    // keep the most recent W accepted bits
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            window <= '0;
        end else if (shift_en) begin
            window <= window_nx;
        end
    end

endmodule

// File: rtl/cfg_word_packer.sv
// Serial-to-parallel word builder.
// Collects W enabled bits MSB first. On the cycle carrying the last bit it
// raises last and presents the whole word on word_nx. Assumes clear is
// pulsed whenever a new word grid must start.
module cfg_word_packer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic         bit_in,
    output logic         last,
    output logic [W-1:0] word_nx
);

    localparam int CW = $clog2(W);

    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  acc;

    // word as it stands once the current bit is included
    assign word_nx = {acc[W-2:0], bit_in};
    assign last    = en && (bit_cnt == CW'(W - 1));

    // accumulate bits and count position within the word
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bit_cnt <= '0;
            acc     <= '0;
        end else if (en) begin
            acc     <= word_nx;
            bit_cnt <= last ? '0 : bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_sync_gate.sv
// Configuration stream sync and identity gate (top).
// Hunts for SYNC_WORD at any bit offset, checks the following word against
// DEVICE_ID, then forwards payload words or latches an error until restart.
// Assumes one bit per cycle at most and inputs stable around the rising edge.
module cfg_sync_gate #(
    parameter int           W         = 32,
    parameter logic [W-1:0] SYNC_WORD = 32'hAA99_5566,
    parameter logic [W-1:0] DEVICE_ID = 32'h0208_8093
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         bit_vld,
    input  logic         restart,
    output logic [W-1:0] word_out,
    output logic         word_vld,
    output logic         sync_found,
    output logic         id_ok,
    output logic         id_err
);

    import cfg_sync_pkg::*;

    cfg_state_t   state;
    logic         hunt_en;
    logic         pack_en;
    logic         sync_hit;
    logic         word_last;
    logic [W-1:0] word_nx;

    // route accepted bits to the hunter or the packer depending on phase
    assign hunt_en = bit_vld && !restart && (state == ST_HUNT);
    assign pack_en = bit_vld && !restart &&
                     ((state == ST_ID) || (state == ST_LOAD));

    cfg_sync_hunter #(
        .W       (W),
        .PATTERN (SYNC_WORD)
    ) u_hunter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .shift_en (hunt_en),
        .bit_in   (bit_in),
        .hit      (sync_hit)
    );

    cfg_word_packer #(
        .W (W)
    ) u_packer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .en      (pack_en),
        .bit_in  (bit_in),
        .last    (word_last),
        .word_nx (word_nx)
    );

    // phase sequencing and the three status flags
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state      <= ST_HUNT;
            sync_found <= 1'b0;
            id_ok      <= 1'b0;
            id_err     <= 1'b0;
        end else begin
            unique case (state)
                ST_HUNT: if (sync_hit) begin
                    state      <= ST_ID;
                    sync_found <= 1'b1;
                end
                ST_ID: if (word_last) begin
                    if (word_nx == DEVICE_ID) begin
                        state <= ST_LOAD;
                        id_ok <= 1'b1;
                    end else begin
                        state  <= ST_FAIL;
                        id_err <= 1'b1;
                    end
                end
                ST_LOAD: ;
                ST_FAIL: ;
                default: state <= ST_HUNT;
            endcase
        end
    end

    // payload word output and its one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            word_out <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if ((state == ST_LOAD) && word_last) begin
                word_out <= word_nx;
                word_vld <= 1'b1;
            end
        end
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(id_ok && id_err)); // R10
    AST_VERDICT_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (id_ok || id_err) |-> sync_found); // R10
    AST_NO_EARLY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> id_ok); // R3
    AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |-> !word_vld); // R5
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_err && !restart) |=> id_err); // R6
    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!sync_found && !id_ok && !id_err && !word_vld)); // R8
    AST_WORD_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(bit_vld)); // R9
    AST_SYNC_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_found) |-> $past(bit_vld)); // R2

endmodule

// File: tb/test_cfg_sync_gate.sv
`timescale 1ns/1ps
module test_cfg_sync_gate;

    localparam logic [31:0] SYNC = 32'hAA99_5566;
    localparam logic [31:0] GOOD = 32'h0208_8093;
    localparam int          NV   = 5;

    // vector table: leading bits, identifier, two payload words, expected verdict
    localparam int          V_LEN [NV] = '{0, 5, 13, 31, 20};
    localparam logic [31:0] V_LEAD[NV] = '{32'h0, 32'h16, 32'h1F0A, 32'h2AAA_5555, 32'hC3C3C};
    localparam logic [31:0] V_ID  [NV] = '{GOOD, GOOD, 32'h0208_8092, GOOD, SYNC};
    localparam logic [31:0] V_P0  [NV] = '{32'hDEAD_BEEF, 32'h1234_5678, 32'h1111_1111, 32'hFFFF_FFFF, 32'h5A5A_5A5A};
    localparam logic [31:0] V_P1  [NV] = '{32'h0000_0001, 32'h9ABC_DEF0, 32'h2222_2222, 32'h0000_0000, 32'hA5A5_A5A5};
    localparam bit          V_OK  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic        restart = 1'b0;
    logic [31:0] word_out;
    logic        word_vld;
    logic        sync_found;
    logic        id_ok;
    logic        id_err;

    int          n_chk = 0;
    int          n_err = 0;
    int          gap = 0;
    int          n_got = 0;
    logic [31:0] got [64];

    always #2.5 clk = ~clk;

    cfg_sync_gate i_cfg_sync_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .bit_vld    (bit_vld),
        .restart    (restart),
        .word_out   (word_out),
        .word_vld   (word_vld),
        .sync_found (sync_found),
        .id_ok      (id_ok),
        .id_err     (id_err)
    );

    // record forwarded words away from the rising edge
    always @(negedge clk) begin
        if (word_vld && n_got < 64) begin
            got[n_got] = word_out;
            n_got = n_got + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            restart = 1'b0;
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        restart = 1'b0;
        if (gap > 0) idle(gap);
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        bit_vld = 1'b0;
        @(negedge clk);
        restart = 1'b0;
        chk(!sync_found && !id_ok && !id_err && !word_vld, "R8 restart clears flags",
            {28'd0, sync_found, id_ok, id_err, word_vld}, 32'd0);
    endtask

    task automatic run_vec(input int v);
        int base;
        do_restart();
        base = n_got;
        for (int i = V_LEN[v] - 1; i >= 0; i--) send_bit(V_LEAD[v][i]);
        for (int i = 31; i >= 1; i--) send_bit(SYNC[i]);
        idle(1);
        chk(!sync_found, "R2 no sync before last pattern bit", {31'd0, sync_found}, 32'd0);
        send_bit(SYNC[0]);
        idle(1);
        chk(sync_found, "R2 sync found", {31'd0, sync_found}, 32'd1);
        chk(n_got == base, "R3 nothing forwarded before sync", n_got - base, 32'd0);
        send_word(V_ID[v]);
        idle(1);
        chk(id_ok == V_OK[v], "R4 id_ok verdict", {31'd0, id_ok}, {31'd0, V_OK[v]});
        chk(id_err == !V_OK[v], "R5 id_err verdict", {31'd0, id_err}, {31'd0, !V_OK[v]});
        send_word(V_P0[v]);
        send_word(V_P1[v]);
        idle(2);
        if (V_OK[v]) begin
            chk(n_got == base + 2, "R7 word count", n_got - base, 32'd2);
            chk(got[base] == V_P0[v], "R7 first word", got[base], V_P0[v]);
            chk(got[base + 1] == V_P1[v], "R7 second word", got[base + 1], V_P1[v]);
        end else begin
            chk(n_got == base, "R5 no words after mismatch", n_got - base, 32'd0);
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int base;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!sync_found && !id_ok && !id_err && !word_vld, "R1 reset state",
            {28'd0, sync_found, id_ok, id_err, word_vld}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // table walk
        for (int v = 0; v < NV; v++) run_vec(v);

        // R9: idle gaps between bits give the same result
        gap = 2;
        run_vec(1);
        gap = 0;

        // R6: error held despite a later valid pattern and identifier
        run_vec(2);
        base = n_got;
        send_word(SYNC);
        send_word(GOOD);
        send_word(32'hCAFE_F00D);
        idle(2);
        chk(id_err && !id_ok, "R6 error sticky", {30'd0, id_ok, id_err}, 32'd1);
        chk(n_got == base, "R6 no words while error held", n_got - base, 32'd0);
        chk(!(id_ok && id_err) && sync_found, "R10 flag consistency",
            {29'd0, sync_found, id_ok, id_err}, 32'd5);

        // R8: bit offered in the restart cycle is discarded
        @(negedge clk);
        restart = 1'b1;
        bit_vld = 1'b1;
        bit_in  = SYNC[31];
        @(negedge clk);
        restart = 1'b0;
        bit_vld = 1'b0;
        for (int i = 30; i >= 0; i--) send_bit(SYNC[i]);
        idle(1);
        chk(!sync_found, "R8 restart-cycle bit discarded", {31'd0, sync_found}, 32'd0);

        // R1: reset in the middle of payload
        do_restart();
        send_word(SYNC);
        send_word(GOOD);
        for (int i = 31; i >= 16; i--) send_bit(1'b1);
        @(negedge clk);
        bit_vld = 1'b0;
        rst_n   = 1'b0;
        @(negedge clk);
        chk(!sync_found && !id_ok && !id_err && !word_vld, "R1 mid-stream reset",
            {28'd0, sync_found, id_ok, id_err, word_vld}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule